// File: doc/BRIEF.md
# Serial Bus Word Manchester Transmitter

This block turns one 16-bit word into a 20-bit-time serial bus word at 1 Mbit/s. Each accepted word is tagged as either a command/status word or a data word. The tag selects which of two 3-bit-time sync shapes goes out first. After the sync come the 16 payload bits, most significant first, in bi-phase (Manchester) coding, and then an odd-parity bit. The system clock runs at 12, 16 or 20 MHz, chosen by a 2-bit setting, so one half bit lasts 6, 8 or 10 clocks. The block drives a pair of complementary line outputs and a transmitter-inhibit output.

Two guards sit beside the serializer. The first is a fail-safe timer that counts clocks of continuous transmission. Once the count reaches 800 µs, the timer forces the line idle and latches a timeout flag that only reset clears. The second is a loopback checker. It samples the block's own receive pair in the middle of every half-bit slot and compares it with what was sent. If the echo was wrong or missing, it emits a one-cycle fail pulse once the word ends.

The encoder is a four-state machine:
- `ST_IDLE` goes to `ST_SYNC` when a word is accepted.
- `ST_SYNC` goes to `ST_BITS` after six half-bit slots.
- `ST_BITS` goes to `ST_PAR` after 32 slots.
- `ST_PAR` returns to `ST_SYNC` if another word is waiting at the end of the word. Otherwise it returns to `ST_IDLE`.
- Every active state drops to `ST_IDLE` once the timeout flag is set.

Top module: `serial_word_tx`

## Requirements
- R1: After reset, and between words, `line_pos` and `line_neg` are 0, `tx_inhibit` is 1, `word_ready` is 1, and `timeout_flag` and `loop_fail` are 0.
- R2: A word is accepted on a clock edge where `word_valid` and `word_ready` are both 1. Its first half-bit slot appears in the cycle right after that edge. A word is 40 half-bit slots. Each slot lasts 6, 8, 10 or 10 clocks for `freq_sel` values 00, 01, 10 or 11.
- R3: With `word_is_data`=0 (command/status), slots 0–2 are high and slots 3–5 are low. With `word_is_data`=1 (data), slots 0–2 are low and slots 3–5 are high. "High" means `line_pos`=1 and `line_neg`=0.
- R4: Slots 6–37 carry `word_data` bit 15 first and bit 0 last, two slots per bit. A 1 is sent high then low, and a 0 is sent low then high. While a word is on the line, `line_neg` is the complement of `line_pos` and `tx_inhibit` is 0.
- R5: Slots 38–39 carry an odd-parity bit over the 16 data bits, coded the same way as the data bits.
- R6: `word_ready` is 0 inside a word and 1 in its last clock. A word offered in that clock starts at once, with no idle gap.
- R7: After 800 × (6, 8, 10 or 10 half-bit clocks × 2) continuous busy cycles (9600, 12800 or 16000 clocks), the outputs go idle in the next cycle. `timeout_flag` then stays 1 and `word_ready` stays 0 until reset.
- R8: `rx_pos`/`rx_neg` are sampled in the middle of each slot and compared with the sent levels. In the cycle after a word's last clock, `loop_fail` pulses for exactly one cycle if any sample differed, and otherwise stays 0.
- R9: A missing echo, with both receive inputs held at 0 for the whole word, also raises that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 12/16/20 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| freq_sel | input | 2 | Clock rate select: 00=12, 01=16, 10/11=20 MHz |
| word_valid | input | 1 | A word is offered |
| word_is_data | input | 1 | 1 = data word sync, 0 = command/status sync |
| word_data | input | 16 | Payload, bit 15 sent first |
| word_ready | output | 1 | Word is taken on this edge if valid |
| line_pos | output | 1 | Positive line drive |
| line_neg | output | 1 | Negative line drive |
| tx_inhibit | output | 1 | High while the transmitter is quiet |
| rx_pos | input | 1 | Positive receive level of the block's own bus |
| rx_neg | input | 1 | Negative receive level of the block's own bus |
| timeout_flag | output | 1 | Latched fail-safe trip |
| loop_fail | output | 1 | One-cycle loopback mismatch pulse |

## Verification
Line levels are due from the cycle after the accept edge. The bench counts falling edges from that edge and checks every clock of each slot against a level it computes itself, so a slot of the wrong length shows up at its edges. The loopback pulse is due one clock after the last slot's final clock and must be gone a clock later; the bench checks exactly those two falling edges. The timeout is checked on the last busy clock (9599 clocks after acceptance at 12 MHz) and on the clock after it, with the valid input held high so that words run back to back.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_BITS,
        ST_PAR
    } mtx_state_e;

    localparam int SYNC_SLOTS = 6;
endpackage

// File: rtl/mtx_bit_timer.sv
module mtx_bit_timer #(
    parameter int MHZ_A = 12,
    parameter int MHZ_B = 16,
    parameter int MHZ_C = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] freq_sel,
    input  logic       run,
    output logic       slot_end,
    output logic       slot_mid
);
    localparam int CW = $clog2(MHZ_C / 2 + 1);

    logic [CW-1:0] half_len;
    logic [CW-1:0] cnt;

    always_comb begin
        unique case (freq_sel)
            2'b00:   half_len = CW'(MHZ_A / 2);
            2'b01:   half_len = CW'(MHZ_B / 2);
            default: half_len = CW'(MHZ_C / 2);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt <= '0;
        else if (!run)                      cnt <= '0;
        else if (cnt == half_len - CW'(1))  cnt <= '0;
        else                                cnt <= cnt + CW'(1);
    end

    assign slot_end = run && (cnt == half_len - CW'(1));
    assign slot_mid = run && (cnt == (half_len >> 1));

    // R2
    slot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < half_len));
endmodule

// File: rtl/mtx_encoder.sv
module mtx_encoder
    import mtx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic              word_is_data,
    input  logic [DATA_W-1:0] word_data,
    input  logic              slot_end,
    input  logic              halt,
    output logic              word_ready,
    output logic              busy,
    output logic              word_end,
    output logic              level,
    output logic              line_pos,
    output logic              line_neg,
    output logic              tx_inhibit
);
    localparam int WORD_SLOTS = SYNC_SLOTS + 2 * DATA_W + 2;
    localparam int SLOT_W     = $clog2(WORD_SLOTS);
    localparam int IDXW       = $clog2(DATA_W);

    mtx_state_e        state, state_n;
    logic [SLOT_W-1:0] slot, slot_n;
    logic [DATA_W-1:0] data_q;
    logic              kind_q;
    logic              last, take;
    logic [IDXW:0]     rel;
    logic [IDXW-1:0]   bit_idx;

    assign busy       = (state != ST_IDLE);
    assign last       = (slot == SLOT_W'(WORD_SLOTS - 1));
    assign word_end   = busy && slot_end && last;
    assign word_ready = !halt && (!busy || word_end);
    assign take       = word_valid && word_ready;

    always_comb begin
        state_n = state;
        slot_n  = slot;
        unique case (state)
            ST_IDLE: begin
                if (take) begin
                    state_n = ST_SYNC;
                    slot_n  = '0;
                end
            end
            ST_SYNC, ST_BITS, ST_PAR: begin
                if (halt) begin
                    state_n = ST_IDLE;
                    slot_n  = '0;
                end else if (slot_end) begin
                    if (last) begin
                        state_n = take ? ST_SYNC : ST_IDLE;
                        slot_n  = '0;
                    end else begin
                        slot_n = slot + SLOT_W'(1);
                        if (slot_n == SLOT_W'(SYNC_SLOTS))         state_n = ST_BITS;
                        if (slot_n == SLOT_W'(WORD_SLOTS - 2))     state_n = ST_PAR;
                    end
                end
            end
            default: begin
                state_n = ST_IDLE;
                slot_n  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            slot   <= '0;
            data_q <= '0;
            kind_q <= 1'b0;
        end else begin
            state <= state_n;
            slot  <= slot_n;
            if (take) begin
                data_q <= word_data;
                kind_q <= word_is_data;
            end
        end
    end

    assign rel     = (IDXW + 1)'(slot - SLOT_W'(SYNC_SLOTS));
    assign bit_idx = rel[IDXW:1];

    always_comb begin
        unique case (state)
            ST_SYNC: level = kind_q ? (slot >= SLOT_W'(SYNC_SLOTS / 2))
                                    : (slot <  SLOT_W'(SYNC_SLOTS / 2));
            ST_BITS: level = data_q[IDXW'(DATA_W - 1) - bit_idx] ^ rel[0];
            ST_PAR:  level = (~^data_q) ^ rel[0];
            default: level = 1'b0;
        endcase
    end

    always_comb begin
        line_pos   = busy && !halt && level;
        line_neg   = busy && !halt && !level;
        tx_inhibit = !(busy && !halt);
    end

    // R4
    lines_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pos && line_neg));
    // R2
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= SLOT_W'(WORD_SLOTS - 1));
    // R6
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && word_valid && !halt) |=> (state == ST_SYNC && slot == '0));
    // R1
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_inhibit |-> (!line_pos && !line_neg));
endmodule

// File: rtl/mtx_failsafe.sv
module mtx_failsafe #(
    parameter int TIMEOUT_US = 800,
    parameter int MHZ_A      = 12,
    parameter int MHZ_B      = 16,
    parameter int MHZ_C      = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] freq_sel,
    input  logic       busy,
    output logic       tripped
);
    localparam int LW = $clog2(TIMEOUT_US * MHZ_C + 1);

    logic [LW-1:0] limit;
    logic [LW-1:0] cnt;

    always_comb begin
        unique case (freq_sel)
            2'b00:   limit = LW'(TIMEOUT_US * MHZ_A);
            2'b01:   limit = LW'(TIMEOUT_US * MHZ_B);
            default: limit = LW'(TIMEOUT_US * MHZ_C);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            tripped <= 1'b0;
        end else if (!busy) begin
            cnt <= '0;
        end else if (!tripped) begin
            if (cnt == limit - LW'(1)) tripped <= 1'b1;
            else                       cnt     <= cnt + LW'(1);
        end
    end

    // R7
    trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tripped |=> tripped);
    // R7
    trip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tripped) |=> !busy);
endmodule

// File: rtl/mtx_loopcheck.sv
module mtx_loopcheck (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_mid,
    input  logic word_end,
    input  logic abort,
    input  logic exp_level,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic loop_fail
);
    logic acc;
    logic miss;

    assign miss = (rx_pos != exp_level) || (rx_neg == exp_level);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc       <= 1'b0;
            loop_fail <= 1'b0;
        end else begin
            loop_fail <= word_end && !abort && acc;
            if (abort || word_end)  acc <= 1'b0;
            else if (slot_mid && miss) acc <= 1'b1;
        end
    end

    // R8
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_fail |=> !loop_fail);
endmodule

// File: rtl/serial_word_tx.sv
module serial_word_tx #(
    parameter int DATA_W     = 16,
    parameter int TIMEOUT_US = 800,
    parameter int MHZ_A      = 12,
    parameter int MHZ_B      = 16,
    parameter int MHZ_C      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        freq_sel,
    input  logic              word_valid,
    input  logic              word_is_data,
    input  logic [DATA_W-1:0] word_data,
    output logic              word_ready,
    output logic              line_pos,
    output logic              line_neg,
    output logic              tx_inhibit,
    input  logic              rx_pos,
    input  logic              rx_neg,
    output logic              timeout_flag,
    output logic              loop_fail
);
    logic busy, slot_end, slot_mid, word_end, level;

    mtx_bit_timer #(.MHZ_A(MHZ_A), .MHZ_B(MHZ_B), .MHZ_C(MHZ_C)) u_timer (
        .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .run(busy),
        .slot_end(slot_end), .slot_mid(slot_mid)
    );

    mtx_encoder #(.DATA_W(DATA_W)) u_enc (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid),
        .word_is_data(word_is_data), .word_data(word_data),
        .slot_end(slot_end), .halt(timeout_flag), .word_ready(word_ready),
        .busy(busy), .word_end(word_end), .level(level),
        .line_pos(line_pos), .line_neg(line_neg), .tx_inhibit(tx_inhibit)
    );

    mtx_failsafe #(.TIMEOUT_US(TIMEOUT_US), .MHZ_A(MHZ_A), .MHZ_B(MHZ_B),
                   .MHZ_C(MHZ_C)) u_fs (
        .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .busy(busy),
        .tripped(timeout_flag)
    );

    mtx_loopcheck u_loop (
        .clk(clk), .rst_n(rst_n), .slot_mid(slot_mid), .word_end(word_end),
        .abort(timeout_flag), .exp_level(level), .rx_pos(rx_pos),
        .rx_neg(rx_neg), .loop_fail(loop_fail)
    );
endmodule

// File: tb/serial_word_tx_bench.sv
module serial_word_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  freq_sel = 2'b00;
    logic        word_valid = 1'b0;
    logic        word_is_data = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_ready, line_pos, line_neg, tx_inhibit;
    logic        timeout_flag, loop_fail;
    logic        flip = 1'b0;
    logic        miss = 1'b0;
    logic        rx_pos, rx_neg;
    int          checks = 0;
    int          failures = 0;

    assign rx_pos = miss ? 1'b0 : (line_pos ^ flip);
    assign rx_neg = miss ? 1'b0 : (line_neg ^ flip);

    always #10 clk = ~clk;

    serial_word_tx u_serial_word_tx (
        .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .word_valid(word_valid),
        .word_is_data(word_is_data), .word_data(word_data),
        .word_ready(word_ready), .line_pos(line_pos), .line_neg(line_neg),
        .tx_inhibit(tx_inhibit), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .timeout_flag(timeout_flag), .loop_fail(loop_fail)
    );

    typedef struct packed {
        logic [1:0]  f;
        logic        d;
        logic [15:0] w;
        logic [1:0]  m;
        logic [5:0]  s;
    } vec_t;

    // m: 0 clean echo, 1 missing echo, 2 echo inverted during slot s
    localparam vec_t VECS [9] = '{
        '{2'd0, 1'b0, 16'hA5C3, 2'd0, 6'd0},
        '{2'd0, 1'b1, 16'h0000, 2'd0, 6'd0},
        '{2'd1, 1'b0, 16'hFFFF, 2'd0, 6'd0},
        '{2'd2, 1'b1, 16'h1234, 2'd0, 6'd0},
        '{2'd3, 1'b0, 16'h8001, 2'd0, 6'd0},
        '{2'd0, 1'b1, 16'h5A5A, 2'd1, 6'd0},
        '{2'd1, 1'b0, 16'h7E81, 2'd2, 6'd20},
        '{2'd2, 1'b1, 16'hC0DE, 2'd2, 6'd39},
        '{2'd0, 1'b0, 16'h0F0F, 2'd2, 6'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int half_of(input logic [1:0] f);
        return (f == 2'b00) ? 6 : (f == 2'b01) ? 8 : 10;
    endfunction

    function automatic logic lvl(input logic d, input logic [15:0] w, input int k);
        if (k < 6) return d ? (k >= 3) : (k < 3);
        else if (k < 38) begin
            logic v;
            v = w[15 - (k - 6) / 2];
            return (((k - 6) % 2) == 0) ? v : !v;
        end else begin
            logic p;
            p = ~^w;
            return (k == 38) ? p : !p;
        end
    endfunction

    task automatic start_word(input logic d, input logic [15:0] w, input bit hold);
        @(negedge clk);
        word_valid   = 1'b1;
        word_is_data = d;
        word_data    = w;
        while (!word_ready) @(negedge clk);
        @(posedge clk);
        #1;
        if (!hold) word_valid = 1'b0;
    endtask

    task automatic check_slots(input logic d, input logic [15:0] w, input int h,
                               input int mode, input int fslot);
        bit ok = 1'b1;
        for (int n = 0; n < 40 * h; n++) begin
            int k;
            logic e;
            @(negedge clk);
            k    = n / h;
            flip = (mode == 2) && (k == fslot);
            miss = (mode == 1);
            e    = lvl(d, w, k);
            if (n % h == 0) ok = 1'b1;
            ok &= (line_pos == e) && (line_neg == !e) && !tx_inhibit;
            if (n % h == h - 1)
                chk(ok, (k == 0) ? "R2/R3" : (k < 6) ? "R3" : (k < 38) ? "R4" : "R5",
                    {line_pos, line_neg}, {e, !e});
            if (n == h)
                chk(!word_ready, "R6 busy", word_ready, 0);
            if (n == 40 * h - 1)
                chk(word_ready, "R6 last", word_ready, 1);
        end
        flip = 1'b0;
        miss = 1'b0;
    endtask

    task automatic tail_check(input bit exp_fail);
        @(negedge clk);
        chk(loop_fail == exp_fail, exp_fail ? "R8/R9 pulse" : "R8 clean", loop_fail, exp_fail);
        chk(tx_inhibit && !line_pos && !line_neg, "R1 idle", {tx_inhibit, line_pos, line_neg}, 3'b100);
        @(negedge clk);
        chk(!loop_fail, "R8 one cycle", loop_fail, 0);
    endtask

    initial begin
        #4000000;
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(word_ready && tx_inhibit && !line_pos && !line_neg && !timeout_flag && !loop_fail,
            "R1 reset", {word_ready, tx_inhibit, line_pos, line_neg, timeout_flag, loop_fail},
            6'b110000);

        foreach (VECS[i]) begin
            freq_sel = VECS[i].f;
            start_word(VECS[i].d, VECS[i].w, 1'b0);
            check_slots(VECS[i].d, VECS[i].w, half_of(VECS[i].f), int'(VECS[i].m), int'(VECS[i].s));
            tail_check(VECS[i].m != 2'd0);
        end

        // R6 back-to-back words without gap
        freq_sel = 2'b00;
        start_word(1'b0, 16'h1357, 1'b1);
        word_is_data = 1'b1;
        word_data    = 16'hBEEF;
        check_slots(1'b0, 16'h1357, 6, 0, 0);
        @(posedge clk);
        #1 word_valid = 1'b0;
        check_slots(1'b1, 16'hBEEF, 6, 0, 0);
        tail_check(1'b0);

        // R1 reset in mid-word returns to idle
        start_word(1'b0, 16'h2222, 1'b0);
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(tx_inhibit && !line_pos && !line_neg && word_ready, "R1 mid reset",
            {tx_inhibit, line_pos, line_neg, word_ready}, 4'b1001);
        rst_n = 1'b1;

        // R7 fail-safe trip after 9600 busy clocks at 12 MHz
        freq_sel = 2'b00;
        start_word(1'b0, 16'h6666, 1'b1);
        for (int n = 0; n <= 9600; n++) begin
            @(negedge clk);
            if (n == 9599)
                chk(!timeout_flag && !tx_inhibit, "R7 before trip",
                    {timeout_flag, tx_inhibit}, 2'b00);
            if (n == 9600)
                chk(timeout_flag && tx_inhibit && !line_pos && !line_neg && !word_ready,
                    "R7 trip", {timeout_flag, tx_inhibit, line_pos, line_neg, word_ready},
                    5'b11000);
        end
        word_valid = 1'b0;
        repeat (50) @(negedge clk);
        chk(timeout_flag && tx_inhibit && !word_ready, "R7 latched",
            {timeout_flag, tx_inhibit, word_ready}, 3'b110);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!timeout_flag && word_ready, "R7 cleared by reset",
            {timeout_flag, word_ready}, 2'b01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule